// File: doc/BRIEF.md
# Twin-Predicated Vector Move Sequencer

This block carries out one element-wise vector move between two register groups of a small integer register file, with an independent predicate mask on the source and on the destination. A one-cycle start pulse captures the vector length, the two base register numbers, and, for each side, a vector-or-scalar flag, a predicate mask with its enable, and a zeroing flag. The block then walks a source element index and a destination element index, each advancing under its own mask, and issues at most one register write per clock cycle. When the walk is over it pulses done.

Each base register number first passes through a per-register remap table. A table entry that is marked active replaces the register number with its stored target. The table is loaded through a plain write port. The register file sits outside the block. Its read port is combinational: the block drives a read index and expects the data back in the same cycle. Its write port accepts a write on every cycle, so the write stream has no back-pressure. A write is presented as write enable, index and data, and it takes effect at the next rising clock edge. The control pins start, busy and done are level signals with no handshake.

Top module: `tpmove_seq`

## Requirements
- R1: A start pulse with vlen equal to 0 produces done in the first cycle after the start edge, with no write. vlen values above 64 are treated as 64.
- R2: When a side's predicate enable is low, that side's mask is taken as all ones. This holds for the source and the destination separately.
- R3: On a side that is a vector with zeroing off, the index moves forward past every element whose mask bit is clear, before the element is accessed.
- R4: When destination mask bit j is set, the contents of register (src base + i) mod 128 are written to register (dst base + j) mod 128.
- R5: When destination mask bit j is clear and destination zeroing is on, zero is written to register (dst base + j) mod 128.
- R6: When source zeroing is on and source mask bit i is clear, the value written is zero instead of the register contents.
- R7: A scalar destination whose mask bit 0 is set ends the move after that write. When both sides are scalar, the move ends after one step. After each step, i grows by one only for a vector source and j grows by one only for a vector destination.
- R8: The move ends when i or j reaches the vector length, or when a skip scan finds no set mask bit at or above the current index. No further write follows in either case.
- R9: A base register number whose remap entry is active is replaced by the entry's target. An inactive entry leaves the number unchanged.
- R10: Each step takes one cycle and writes at most one register. Done is a one-cycle pulse in the cycle after the final step. Busy is high from the cycle after start until done, and a start pulse while busy is ignored.
- R11: After reset, busy, done and wr_en are low and every remap entry is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move (sampled while idle) |
| vlen | input | 7 | Vector length, clamped to 64 |
| src_reg | input | 7 | Source base register number |
| dst_reg | input | 7 | Destination base register number |
| src_vec | input | 1 | Source is a vector (1) or scalar (0) |
| dst_vec | input | 1 | Destination is a vector (1) or scalar (0) |
| src_pen | input | 1 | Source predicate enable |
| dst_pen | input | 1 | Destination predicate enable |
| src_mask | input | 64 | Source predicate, bit n for element n |
| dst_mask | input | 64 | Destination predicate, bit n for element n |
| src_zero | input | 1 | Source zeroing |
| dst_zero | input | 1 | Destination zeroing |
| map_we | input | 1 | Remap table write strobe |
| map_sel | input | 7 | Remap entry to write |
| map_act | input | 1 | Active flag for the entry |
| map_tgt | input | 7 | Target register number for the entry |
| rd_idx | output | 7 | Register file read index |
| rd_data | input | 64 | Register file read data, same cycle |
| wr_en | output | 1 | Register file write enable |
| wr_idx | output | 7 | Register file write index |
| wr_data | output | 64 | Register file write data |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle end-of-move pulse |

## Verification
For each move the bench works out the number of loop steps N from the requirements. Done is due at the (N+1)-th falling edge after the start edge, which is the first falling edge for a zero length. The bench counts falling edges until done and compares that count with N+1. A write presented in a step cycle lands at the rising edge that closes the cycle. For that reason the bench compares the whole register file and the number of writes at the falling edge where done is seen, when the last write has already landed and no further write can follow.

// File: rtl/tpmove_pkg.sv
package tpmove_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} tpm_state_e;
  localparam int SIDE_SRC = 0;
  localparam int SIDE_DST = 1;
endpackage

// File: rtl/tpmove_remap.sv
module tpmove_remap #(
  parameter int NREG = 128,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] wsel,
  input  logic          wact,
  input  logic [RW-1:0] wtgt,
  input  logic [RW-1:0] sel_a,
  input  logic [RW-1:0] sel_b,
  output logic [RW-1:0] map_a,
  output logic [RW-1:0] map_b
);
  logic          act_q [NREG];
  logic [RW-1:0] tgt_q [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) act_q[k] <= 1'b0;
    end else if (we) begin
      act_q[wsel] <= wact;
    end
  end

  always_ff @(posedge clk) begin
    if (we) tgt_q[wsel] <= wtgt;
  end

  assign map_a = act_q[sel_a] ? tgt_q[sel_a] : sel_a;
  assign map_b = act_q[sel_b] ? tgt_q[sel_b] : sel_b;
endmodule

// File: rtl/tpmove_ffs.sv
module tpmove_ffs #(
  parameter int W  = 64,
  parameter int IW = 7
) (
  input  logic [W-1:0]  mask,
  input  logic [IW-1:0] from,
  output logic          found,
  output logic [IW-1:0] pos
);
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int b = W - 1; b >= 0; b--) begin
      if (mask[b] && (IW'(b) >= from)) begin
        found = 1'b1;
        pos   = IW'(b);
      end
    end
  end
endmodule

// File: rtl/tpmove_seq.sv
module tpmove_seq #(
  parameter int NREG  = 128,
  parameter int XLEN  = 64,
  parameter int MAXVL = 64,
  localparam int RW = $clog2(NREG),
  localparam int LW = $clog2(MAXVL),
  localparam int IW = LW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IW-1:0]    vlen,
  input  logic [RW-1:0]    src_reg,
  input  logic [RW-1:0]    dst_reg,
  input  logic             src_vec,
  input  logic             dst_vec,
  input  logic             src_pen,
  input  logic             dst_pen,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [MAXVL-1:0] dst_mask,
  input  logic             src_zero,
  input  logic             dst_zero,
  input  logic             map_we,
  input  logic [RW-1:0]    map_sel,
  input  logic             map_act,
  input  logic [RW-1:0]    map_tgt,
  output logic [RW-1:0]    rd_idx,
  input  logic [XLEN-1:0]  rd_data,
  output logic             wr_en,
  output logic [RW-1:0]    wr_idx,
  output logic [XLEN-1:0]  wr_data,
  output logic             busy,
  output logic             done
);
  import tpmove_pkg::*;

  tpm_state_e state_q;
  logic [IW-1:0]    vl_q;
  logic [RW-1:0]    base_q  [2];
  logic [MAXVL-1:0] msk_q   [2];
  logic             vec_q   [2];
  logic             zer_q   [2];
  logic [IW-1:0]    idx_q   [2];

  logic [IW-1:0]    eff     [2];
  logic             ok      [2];
  logic             pbit    [2];
  logic [IW-1:0]    nxt     [2];

  logic [RW-1:0] map_src, map_dst;
  logic          in_run, stop, step, finish;

  tpmove_remap #(.NREG(NREG)) u_remap (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (map_we),
    .wsel  (map_sel),
    .wact  (map_act),
    .wtgt  (map_tgt),
    .sel_a (src_reg),
    .sel_b (dst_reg),
    .map_a (map_src),
    .map_b (map_dst)
  );

  assign in_run = (state_q == ST_RUN);

  for (genvar g = 0; g < 2; g++) begin : g_side
    logic          scan, fnd;
    logic [IW-1:0] fpos;

    tpmove_ffs #(.W(MAXVL), .IW(IW)) u_ffs (
      .mask  (msk_q[g]),
      .from  (idx_q[g]),
      .found (fnd),
      .pos   (fpos)
    );

    assign scan    = vec_q[g] && !zer_q[g];
    assign eff[g]  = scan ? fpos : idx_q[g];
    assign ok[g]   = scan ? fnd : 1'b1;
    assign pbit[g] = msk_q[g][eff[g][LW-1:0]];
    assign nxt[g]  = eff[g] + (vec_q[g] ? IW'(1) : IW'(0));
  end

  assign stop = in_run && (!ok[SIDE_SRC] || !ok[SIDE_DST] ||
                           (eff[SIDE_SRC] >= vl_q) || (eff[SIDE_DST] >= vl_q));
  assign step = in_run && !stop;

  assign finish = stop ||
                  (step && ((!vec_q[SIDE_DST] && pbit[SIDE_DST]) ||
                            (!vec_q[SIDE_SRC] && !vec_q[SIDE_DST])));

  assign rd_idx  = base_q[SIDE_SRC] + RW'(eff[SIDE_SRC]);
  assign wr_idx  = base_q[SIDE_DST] + RW'(eff[SIDE_DST]);
  assign wr_en   = step && (pbit[SIDE_DST] || zer_q[SIDE_DST]);
  assign wr_data = (pbit[SIDE_DST] && !(zer_q[SIDE_SRC] && !pbit[SIDE_SRC]))
                   ? rd_data : '0;

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vl_q    <= '0;
      for (int g = 0; g < 2; g++) begin
        base_q[g] <= '0;
        msk_q[g]  <= '0;
        vec_q[g]  <= 1'b0;
        zer_q[g]  <= 1'b0;
        idx_q[g]  <= '0;
      end
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            vl_q             <= (vlen > IW'(MAXVL)) ? IW'(MAXVL) : vlen;
            base_q[SIDE_SRC] <= map_src;
            base_q[SIDE_DST] <= map_dst;
            msk_q[SIDE_SRC]  <= src_pen ? src_mask : '1;
            msk_q[SIDE_DST]  <= dst_pen ? dst_mask : '1;
            vec_q[SIDE_SRC]  <= src_vec;
            vec_q[SIDE_DST]  <= dst_vec;
            zer_q[SIDE_SRC]  <= src_zero;
            zer_q[SIDE_DST]  <= dst_zero;
            idx_q[SIDE_SRC]  <= '0;
            idx_q[SIDE_DST]  <= '0;
            state_q          <= (vlen == '0) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (finish) begin
            state_q <= ST_FIN;
          end else begin
            idx_q[SIDE_SRC] <= nxt[SIDE_SRC];
            idx_q[SIDE_DST] <= nxt[SIDE_DST];
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tpmove_seq_chk.sv
module tpmove_seq_chk #(
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [IW-1:0] vlen,
  input logic          busy,
  input logic          done,
  input logic          wr_en
);
  p_wr_in_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy && !done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  p_empty_move_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (vlen == '0) |=> done && !wr_en);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en && !done);
endmodule

bind tpmove_seq tpmove_seq_chk #(.IW(IW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .vlen  (vlen),
  .busy  (busy),
  .done  (done),
  .wr_en (wr_en)
);

// File: tb/tb_tpmove_seq.sv
`timescale 1ns/1ps
module tb_tpmove_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vlen = '0, src_reg = '0, dst_reg = '0;
  logic        src_vec = 0, dst_vec = 0, src_pen = 0, dst_pen = 0;
  logic [63:0] src_mask = '0, dst_mask = '0;
  logic        src_zero = 0, dst_zero = 0;
  logic        map_we = 0, map_act = 0;
  logic [6:0]  map_sel = '0, map_tgt = '0;
  logic [6:0]  rd_idx, wr_idx;
  logic [63:0] rd_data, wr_data;
  logic        wr_en, busy, done;

  logic [63:0] mem [128];
  logic        bt_act [128];
  logic [6:0]  bt_tgt [128];
  int nchk = 0, nfail = 0, nwr = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  tpmove_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
    .src_reg(src_reg), .dst_reg(dst_reg), .src_vec(src_vec), .dst_vec(dst_vec),
    .src_pen(src_pen), .dst_pen(dst_pen), .src_mask(src_mask), .dst_mask(dst_mask),
    .src_zero(src_zero), .dst_zero(dst_zero), .map_we(map_we), .map_sel(map_sel),
    .map_act(map_act), .map_tgt(map_tgt), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .busy(busy), .done(done)
  );

  assign rd_data = mem[rd_idx];
  always @(posedge clk) if (wr_en) begin
    mem[wr_idx] <= wr_data;
    nwr <= nwr + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  task automatic map_write(input [6:0] sel, input bit act, input [6:0] tgt);
    @(negedge clk);
    map_we = 1; map_sel = sel; map_act = act; map_tgt = tgt;
    bt_act[sel] = act; bt_tgt[sel] = tgt;
    @(negedge clk);
    map_we = 0;
  endtask

  // One move: bench model, drive, and compare latency, write count, register file.
  task automatic run_op(input [6:0] vl, input [6:0] rs, input [6:0] rd,
                        input bit sv, input bit dv, input bit spen, input bit dpen,
                        input bit sz, input bit dz, input [63:0] sm, input [63:0] dm,
                        input [63:0] seed, input string tag, input bit poke);
    logic [63:0] expm [128];
    logic [63:0] ps, pd;
    int vlc, i, j, ia, ja, runs, wexp, k, bs, bd, w0;
    bit sok, dok, pbd, pbs, mism;
    @(negedge clk);
    for (int r = 0; r < 128; r++) begin
      mem[r]  = 64'(r) * 64'h9E37_79B9_7F4A_7C15 + seed;
      expm[r] = mem[r];
    end
    bs = bt_act[rs] ? int'(bt_tgt[rs]) : int'(rs);
    bd = bt_act[rd] ? int'(bt_tgt[rd]) : int'(rd);
    ps = spen ? sm : '1;
    pd = dpen ? dm : '1;
    vlc = (vl > 64) ? 64 : int'(vl);
    i = 0; j = 0; runs = 0; wexp = 0;
    if (vlc != 0) begin
      forever begin
        runs++;
        ia = i; sok = 1;
        if (sv && !sz) begin
          sok = 0;
          for (int b = i; b < 64; b++) if (ps[b]) begin ia = b; sok = 1; break; end
        end
        ja = j; dok = 1;
        if (dv && !dz) begin
          dok = 0;
          for (int b = j; b < 64; b++) if (pd[b]) begin ja = b; dok = 1; break; end
        end
        if (!sok || !dok || ia >= vlc || ja >= vlc) break;
        pbd = pd[ja]; pbs = ps[ia];
        if (pbd || dz) begin
          expm[(bd + ja) % 128] = (pbd && !(sz && !pbs)) ? expm[(bs + ia) % 128] : 64'd0;
          wexp++;
        end
        if ((!dv && pbd) || (!sv && !dv)) break;
        i = ia + int'(sv); j = ja + int'(dv);
      end
    end
    w0 = nwr;
    vlen = vl; src_reg = rs; dst_reg = rd; src_vec = sv; dst_vec = dv;
    src_pen = spen; dst_pen = dpen; src_zero = sz; dst_zero = dz;
    src_mask = sm; dst_mask = dm; start = 1;
    @(negedge clk);
    start = 0;
    k = 1;
    while (!done && k < 400) begin
      @(negedge clk);
      k++;
      if (poke && k == 3) begin
        start = 1; vlen = 7'd0;
      end else begin
        start = 0;
      end
    end
    start = 0;
    check(k == runs + 1, poke ? "R10" : "R10", {tag, " done latency"}, k, runs + 1);
    check(nwr - w0 == wexp, "R10", {tag, " write count"}, nwr - w0, wexp);
    mism = 0;
    for (int r = 0; r < 128; r++) if (mem[r] !== expm[r]) begin
      if (!mism) check(0, tag, $sformatf("register %0d", r), mem[r], expm[r]);
      mism = 1;
    end
    if (!mism) check(1, tag, "registers", 0, 0);
    @(negedge clk);
    check(!done && !busy, "R10", {tag, " done one cycle"}, done, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    logic [63:0] pat [4];
    string tag;
    bit sv, dv, sp, dp, sz, dz;
    int vls [5];
    for (int r = 0; r < 128; r++) begin bt_act[r] = 0; bt_tgt[r] = '0; end
    pat[0] = 64'hA5C3_0F1E_9B72_4D68;
    pat[1] = 64'h0000_0000_0000_0010;
    pat[2] = 64'h0000_0000_0000_0000;
    pat[3] = 64'hFFFF_0000_FFFF_0001;
    vls[0] = 0; vls[1] = 1; vls[2] = 5; vls[3] = 64; vls[4] = 70;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !wr_en, "R11", "reset outputs", {busy, done, wr_en}, 0);

    // R11: no remap active after reset, so bases are used as given (R4 with wrap).
    run_op(7'd8, 7'd3, 7'd124, 1, 1, 0, 0, 0, 0, '0, '0, 64'd11, "R11", 0);
    // R1: empty move and clamp of vlen above 64 (R8).
    run_op(7'd0, 7'd2, 7'd50, 1, 1, 0, 0, 0, 0, '0, '0, 64'd5, "R1", 0);
    run_op(7'd127, 7'd0, 7'd64, 1, 1, 0, 0, 0, 0, '0, '0, 64'd6, "R8", 0);

    // Near-exhaustive sweep of flags, lengths and masks.
    for (int m = 0; m < 3; m++) begin
      for (int v = 0; v < 5; v++) begin
        for (int c = 0; c < 64; c++) begin
          {sv, dv, sp, dp, sz, dz} = 6'(c);
          if (vls[v] == 0) tag = "R1";
          else if (m == 2 && (sp || dp)) tag = "R8";
          else if (dz && dp) tag = "R5";
          else if (sz && sp) tag = "R6";
          else if (!dv || !sv) tag = "R7";
          else if (!sp || !dp) tag = "R2";
          else tag = "R3";
          run_op(7'(vls[v]), 7'd10, 7'd100, sv, dv, sp, dp, sz, dz,
                 pat[m], {pat[(m + 1) % 4][31:0], pat[(m + 3) % 4][63:32]},
                 64'(c + 100 * v), tag, 0);
        end
      end
    end
    // R4: plain copy with all bits set on both sides.
    run_op(7'd64, 7'd0, 7'd64, 1, 1, 1, 1, 0, 0, '1, '1, 64'd77, "R4", 0);

    // R9: active remap replaces the base, inactive entry keeps it.
    map_write(7'd3, 1, 7'd40);
    map_write(7'd5, 1, 7'd90);
    map_write(7'd6, 0, 7'd1);
    run_op(7'd4, 7'd3, 7'd5, 1, 1, 0, 1, 0, 0, '0, 64'h5, 64'd21, "R9", 0);
    run_op(7'd4, 7'd6, 7'd7, 1, 1, 0, 0, 0, 0, '0, '0, 64'd22, "R9", 0);
    run_op(7'd3, 7'd7, 7'd3, 1, 0, 0, 1, 0, 0, '0, 64'h1, 64'd23, "R9", 0);

    // R10: start pulse during a move has no effect.
    run_op(7'd64, 7'd20, 7'd70, 1, 1, 1, 1, 0, 0, pat[0], pat[3], 64'd31, "R10", 1);

    finish_run();
  end
endmodule